// File: doc/BRIEF.md
# Two-Buffer Write-Combining Store Queue

The block holds two line buffers of eight 32-bit words each, sixteen word slots in all. A processor fills the slots one word at a time through a simple write port and can read any slot back in the same cycle. When a buffer is complete, a flush command copies that whole 32-byte buffer to external memory as one burst of eight word beats. Each beat waits for the memory side to be ready.

A flush target is built in one of two ways. In direct mode, the line-address bits of the flush address are joined to a small upper-address register that belongs to the buffer being flushed. In translated mode, the flush address has already been mapped by an earlier stage, so it is used as given after masking. A two-state sequencer runs the burst. In SQ_IDLE it accepts a flush, latches the buffer and target, and moves to SQ_BURST. In SQ_BURST it sends one beat per ready cycle. After the eighth beat is accepted it returns to SQ_IDLE. While the burst runs, the buffer being sent is protected from processor writes. The other buffer stays writable.

Top module: `sq_burst_queue`

## Requirements
- R1: After reset, every slot reads zero, both upper-address registers are zero, `flush_ready` is 1 and `bw_valid` is 0.
- R2: A write with `cpu_wr`=1 that is accepted stores `cpu_wdata` into the slot numbered `cpu_idx` (processor address bits 5:2). `cpu_rdata` shows the slot numbered `cpu_idx` in the same cycle.
- R3: Slot index bit 3 selects the buffer: slots 0-7 form buffer 0 and slots 8-15 form buffer 1. A flush works on the buffer named by `flush_addr` bit 5.
- R4: In direct mode (`flush_xlat`=0), the target is `flush_addr[25:5]` at bits 25:5, the selected buffer's upper-address register at bits 28:26, and zero in all other bits.
- R5: In translated mode (`flush_xlat`=1), the target is `flush_addr & 32'h1FFFFFE0`, and the upper-address registers have no effect.
- R6: A burst has exactly eight beats, sent in ascending slot order of the chosen buffer. `bw_last` is high only on the eighth beat, and `bw_addr` holds the target for the whole burst.
- R7: A beat advances only in a cycle where `bw_valid` and `bw_ready` are both 1. While `bw_ready` is 0, `bw_data` and `bw_last` hold their values.
- R8: `flush_ready` is 0 from the cycle after a flush is accepted until the last beat is accepted. A flush command raised in that window is dropped and starts no burst.
- R9: During a burst, `cpu_wr_ready` is 0 for slots of the buffer being sent, and a write to them changes nothing. Writes to the other buffer are accepted.
- R10: A pulse on `hi_we` loads `hi_wdata` into upper-address register `hi_idx` (0 or 1). The other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor word write request |
| cpu_idx | input | 4 | Slot index (processor address bits 5:2) |
| cpu_wdata | input | 32 | Write data |
| cpu_wr_ready | output | 1 | Write to `cpu_idx` may be accepted this cycle |
| cpu_rdata | output | 32 | Contents of slot `cpu_idx` |
| hi_we | input | 1 | Upper-address register write strobe |
| hi_idx | input | 1 | Which buffer's upper-address register to write |
| hi_wdata | input | 3 | Upper-address value |
| flush_valid | input | 1 | Flush command |
| flush_addr | input | 32 | Flush address; bit 5 picks the buffer |
| flush_xlat | input | 1 | 1: address already translated |
| flush_ready | output | 1 | Sequencer idle, flush accepted |
| bw_valid | output | 1 | Burst beat valid |
| bw_addr | output | 32 | Burst target address, 32-byte aligned |
| bw_data | output | 32 | Beat data |
| bw_last | output | 1 | Final beat of the burst |
| bw_ready | input | 1 | Memory side accepts the beat |

## Verification
The bench builds the block with its default parameters: two buffers of eight words, and a 3-bit upper-address field at bit 26 of a 32-bit address. With these values it can reach every slot index, both buffer selections, the largest upper-address value (7), and flush addresses whose bits above bit 28 and below bit 5 are set and must be dropped. Eight-beat bursts keep irregular stall patterns on `bw_ready` short enough to cover both buffers, both address modes, and writes made during a burst.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [0:0] {
        SQ_IDLE  = 1'b0,
        SQ_BURST = 1'b1
    } sq_state_e;

endpackage

// File: rtl/sq_slots.sv
module sq_slots #(
    parameter int NUM_BUF = 2,
    parameter int WORDS   = 8,
    parameter int DATA_W  = 32,
    localparam int SLOTS  = NUM_BUF * WORDS,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int BUF_W  = $clog2(NUM_BUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    input  logic [IDX_W-1:0]  bidx,
    output logic [DATA_W-1:0] bdata,
    input  logic              lock_on,
    input  logic [BUF_W-1:0]  lock_buf
);

    logic [DATA_W-1:0] mem [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // processor read port and burst read port are independent
    assign rdata = mem[ridx];
    assign bdata = mem[bidx];

    // the buffer being streamed out must never take a write
    AST_LOCKED_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock_on) |-> (widx[IDX_W-1 -: BUF_W] != lock_buf)); // R9

endmodule

// File: rtl/sq_hiaddr.sv
module sq_hiaddr #(
    parameter int NUM_BUF = 2,
    parameter int HI_W    = 3,
    localparam int BUF_W  = $clog2(NUM_BUF)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [BUF_W-1:0]        idx,
    input  logic [HI_W-1:0]         wdata,
    output logic [NUM_BUF*HI_W-1:0] hi_flat
);

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_hi
        logic [HI_W-1:0] hi_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (we && (idx == BUF_W'(g))) begin
                hi_q <= wdata;
            end
        end
        assign hi_flat[g*HI_W +: HI_W] = hi_q;
    end

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(hi_flat)); // R10

endmodule

// File: rtl/sq_target.sv
module sq_target #(
    parameter int ADDR_W   = 32,
    parameter int HI_W     = 3,
    parameter int HI_LSB   = 26,
    parameter int LINE_LSB = 5,
    localparam int TOP     = HI_LSB + HI_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              xlat,
    input  logic [HI_W-1:0]   hi,
    output logic [ADDR_W-1:0] target
);

    // bits outside the line-address window never reach the target
    logic unused_bits;
    assign unused_bits = ^{addr[ADDR_W-1:TOP], addr[LINE_LSB-1:0]};

    always_comb begin
        target = '0;
        if (xlat) begin
            target[TOP-1:LINE_LSB] = addr[TOP-1:LINE_LSB];
        end else begin
            target[HI_LSB-1:LINE_LSB] = addr[HI_LSB-1:LINE_LSB];
            target[TOP-1:HI_LSB]      = hi;
        end
    end

endmodule

// File: rtl/sq_flush_fsm.sv
module sq_flush_fsm
    import sq_pkg::*;
#(
    parameter int WORDS   = 8,
    parameter int BUF_W   = 1,
    parameter int ADDR_W  = 32,
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_valid,
    input  logic [BUF_W-1:0]        flush_buf,
    input  logic [ADDR_W-1:0]       flush_target,
    output logic                    flush_ready,
    input  logic                    bw_ready,
    output logic                    bw_valid,
    output logic [ADDR_W-1:0]       bw_addr,
    output logic                    bw_last,
    output logic [BUF_W+WORD_W-1:0] burst_idx,
    output logic                    busy,
    output logic [BUF_W-1:0]        busy_buf
);

    localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);
    localparam logic [WORD_W-1:0] ONE_BEAT  = WORD_W'(1);

    sq_state_e         state_q, state_d;
    logic [WORD_W-1:0] beat_q;
    logic [BUF_W-1:0]  buf_q;
    logic [ADDR_W-1:0] addr_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (flush_valid) state_d = SQ_BURST;
            SQ_BURST: if (bw_ready && (beat_q == LAST_BEAT)) state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // burst context: buffer, target, beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            buf_q  <= '0;
            addr_q <= '0;
        end else if ((state_q == SQ_IDLE) && flush_valid) begin
            beat_q <= '0;
            buf_q  <= flush_buf;
            addr_q <= flush_target;
        end else if ((state_q == SQ_BURST) && bw_ready) begin
            beat_q <= beat_q + ONE_BEAT;
        end
    end

    // outputs
    always_comb begin
        flush_ready = 1'b0;
        bw_valid    = 1'b0;
        bw_last     = 1'b0;
        busy        = 1'b0;
        unique case (state_q)
            SQ_IDLE: flush_ready = 1'b1;
            SQ_BURST: begin
                bw_valid = 1'b1;
                busy     = 1'b1;
                bw_last  = (beat_q == LAST_BEAT);
            end
            default: flush_ready = 1'b0;
        endcase
        bw_addr   = addr_q;
        burst_idx = {buf_q, beat_q};
        busy_buf  = buf_q;
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && !(bw_ready && bw_last)) |=> (bw_valid && $stable(bw_addr))); // R6
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && bw_ready && !bw_last) |=> (beat_q == $past(beat_q) + ONE_BEAT)); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && !bw_ready) |=> (bw_valid && $stable(beat_q))); // R7
    AST_NO_FLUSH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> !flush_ready); // R8

endmodule

// File: rtl/sq_burst_queue.sv
module sq_burst_queue #(
    parameter int NUM_BUF  = 2,
    parameter int WORDS    = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int HI_W     = 3,
    parameter int HI_LSB   = 26,
    localparam int SLOTS    = NUM_BUF * WORDS,
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int BUF_W    = $clog2(NUM_BUF),
    localparam int WORD_W   = $clog2(WORDS),
    localparam int LINE_LSB = 2 + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_wr_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              hi_we,
    input  logic [BUF_W-1:0]  hi_idx,
    input  logic [HI_W-1:0]   hi_wdata,
    input  logic              flush_valid,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              flush_xlat,
    output logic              flush_ready,
    output logic              bw_valid,
    output logic [ADDR_W-1:0] bw_addr,
    output logic [DATA_W-1:0] bw_data,
    output logic              bw_last,
    input  logic              bw_ready
);

    logic [NUM_BUF*HI_W-1:0] hi_flat;
    logic [BUF_W-1:0]        flush_buf;
    logic [HI_W-1:0]         hi_sel;
    logic [ADDR_W-1:0]       target;
    logic [IDX_W-1:0]        burst_idx;
    logic                    busy;
    logic [BUF_W-1:0]        busy_buf;
    logic                    slot_we;

    assign flush_buf    = flush_addr[LINE_LSB +: BUF_W];
    assign hi_sel       = hi_flat[flush_buf*HI_W +: HI_W];
    assign cpu_wr_ready = !(busy && (cpu_idx[IDX_W-1 -: BUF_W] == busy_buf));
    assign slot_we      = cpu_wr && cpu_wr_ready;

    sq_slots #(.NUM_BUF(NUM_BUF), .WORDS(WORDS), .DATA_W(DATA_W)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (slot_we),
        .widx     (cpu_idx),
        .wdata    (cpu_wdata),
        .ridx     (cpu_idx),
        .rdata    (cpu_rdata),
        .bidx     (burst_idx),
        .bdata    (bw_data),
        .lock_on  (busy),
        .lock_buf (busy_buf)
    );

    sq_hiaddr #(.NUM_BUF(NUM_BUF), .HI_W(HI_W)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (hi_we),
        .idx     (hi_idx),
        .wdata   (hi_wdata),
        .hi_flat (hi_flat)
    );

    sq_target #(.ADDR_W(ADDR_W), .HI_W(HI_W), .HI_LSB(HI_LSB), .LINE_LSB(LINE_LSB)) u_target (
        .addr   (flush_addr),
        .xlat   (flush_xlat),
        .hi     (hi_sel),
        .target (target)
    );

    sq_flush_fsm #(.WORDS(WORDS), .BUF_W(BUF_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_valid  (flush_valid),
        .flush_buf    (flush_buf),
        .flush_target (target),
        .flush_ready  (flush_ready),
        .bw_ready     (bw_ready),
        .bw_valid     (bw_valid),
        .bw_addr      (bw_addr),
        .bw_last      (bw_last),
        .burst_idx    (burst_idx),
        .busy         (busy),
        .busy_buf     (busy_buf)
    );

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> (bw_addr[LINE_LSB-1:0] == '0)); // R4

endmodule

// File: tb/sq_burst_queue_test.sv
module sq_burst_queue_test;

    logic        clk;
    logic        rst_n;
    logic        cpu_wr;
    logic [3:0]  cpu_idx;
    logic [31:0] cpu_wdata;
    logic        cpu_wr_ready;
    logic [31:0] cpu_rdata;
    logic        hi_we;
    logic [0:0]  hi_idx;
    logic [2:0]  hi_wdata;
    logic        flush_valid;
    logic [31:0] flush_addr;
    logic        flush_xlat;
    logic        flush_ready;
    logic        bw_valid;
    logic [31:0] bw_addr;
    logic [31:0] bw_data;
    logic        bw_last;
    logic        bw_ready;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_mem [16];

    sq_burst_queue uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr(cpu_wr), .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata),
        .cpu_wr_ready(cpu_wr_ready), .cpu_rdata(cpu_rdata),
        .hi_we(hi_we), .hi_idx(hi_idx), .hi_wdata(hi_wdata),
        .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_xlat(flush_xlat),
        .flush_ready(flush_ready),
        .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_data(bw_data),
        .bw_last(bw_last), .bw_ready(bw_ready)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // {slot index, data}: scattered order covers every slot
    localparam logic [35:0] WR_VEC [16] = '{
        {4'd9,  32'h0909_5AA5}, {4'd2,  32'h0202_C33C}, {4'd15, 32'h0F0F_1234},
        {4'd0,  32'h0000_FFFF}, {4'd7,  32'h0707_8001}, {4'd12, 32'h0C0C_7E7E},
        {4'd4,  32'h0404_A0A0}, {4'd11, 32'h0B0B_0F0F}, {4'd1,  32'h0101_DEAD},
        {4'd14, 32'h0E0E_BEEF}, {4'd6,  32'h0606_6006}, {4'd8,  32'h0808_CAFE},
        {4'd3,  32'h0303_3003}, {4'd13, 32'h0D0D_F00D}, {4'd5,  32'h0505_5555},
        {4'd10, 32'h0A0A_AAAA}
    };

    // {upper value, translated, flush address, expected target}
    localparam logic [67:0] FL_VEC [4] = '{
        {3'd5, 1'b0, 32'h0123_4560, 32'h1523_4560},
        {3'd3, 1'b0, 32'hFFFF_FFC0, 32'h0FFF_FFC0},
        {3'd7, 1'b1, 32'hE345_67A0, 32'h0345_67A0},
        {3'd2, 1'b1, 32'h7FFF_FFDF, 32'h1FFF_FFC0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cpu_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_idx = idx; cpu_wdata = d;
        #5 chk("R2 write ready", {31'b0, cpu_wr_ready}, 32'd1);
        @(negedge clk);
        cpu_wr = 1'b0;
        exp_mem[idx] = d;
    endtask

    task automatic set_hi(input logic idx, input logic [2:0] v);
        @(negedge clk);
        hi_we = 1'b1; hi_idx = idx; hi_wdata = v;
        @(negedge clk);
        hi_we = 1'b0;
    endtask

    task automatic run_beats(input int base, input logic [31:0] tgt,
                             input logic [15:0] mask, input string tag);
        int b;
        int cyc;
        logic rdy;
        b = 0;
        cyc = 0;
        while (b < 8) begin
            rdy = (cyc < 16) ? !mask[cyc] : 1'b1;
            bw_ready = rdy;
            #5;
            chk({tag, " R6 valid"}, {31'b0, bw_valid}, 32'd1);
            chk({tag, " R4 R5 R6 addr"}, bw_addr, tgt);
            chk({tag, " R3 R6 R7 data"}, bw_data, exp_mem[base + b]);
            chk({tag, " R6 R7 last"}, {31'b0, bw_last}, {31'b0, (b == 7)});
            if (rdy) b++;
            cyc++;
            @(negedge clk);
        end
        bw_ready = 1'b0;
        #5;
        chk({tag, " R6 burst end"}, {31'b0, bw_valid}, 32'd0);
        chk({tag, " R8 ready again"}, {31'b0, flush_ready}, 32'd1);
    endtask

    task automatic do_flush(input logic [31:0] a, input logic x, input logic [31:0] tgt,
                            input logic [15:0] mask, input string tag);
        @(negedge clk);
        flush_valid = 1'b1; flush_addr = a; flush_xlat = x;
        #5 chk({tag, " R8 accept"}, {31'b0, flush_ready}, 32'd1);
        @(negedge clk);
        flush_valid = 1'b0;
        run_beats(a[5] ? 8 : 0, tgt, mask, tag);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        rst_n = 1'b0; cpu_wr = 1'b0; cpu_idx = '0; cpu_wdata = '0;
        hi_we = 1'b0; hi_idx = '0; hi_wdata = '0;
        flush_valid = 1'b0; flush_addr = '0; flush_xlat = 1'b0; bw_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1 reset state
        chk("R1 flush_ready", {31'b0, flush_ready}, 32'd1);
        chk("R1 bw_valid", {31'b0, bw_valid}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            cpu_idx = 4'(i);
            #1 chk("R1 slot zero", cpu_rdata, 32'd0);
        end
        // R1 upper registers zero: direct flush keeps bits 28:26 clear
        do_flush(32'h0000_0040, 1'b0, 32'h0000_0040, 16'h0000, "R1 reset flush");

        // R2 table of writes, then readback
        for (int i = 0; i < 16; i++) begin
            cpu_write(WR_VEC[i][35:32], WR_VEC[i][31:0]);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            cpu_idx = WR_VEC[i][35:32];
            #5 chk("R2 readback", cpu_rdata, WR_VEC[i][31:0]);
        end

        // R3 R4 R5 R10 flush table
        for (int i = 0; i < 4; i++) begin
            set_hi(FL_VEC[i][32 + 5], FL_VEC[i][67:65]);
            do_flush(FL_VEC[i][63:32], FL_VEC[i][64], FL_VEC[i][31:0], 16'h0000,
                     "R4 R5 R10 table");
        end

        // R10: only register 1 changes; buffer 0 still uses value 2
        set_hi(1'b1, 3'd6);
        do_flush(32'h0000_0000, 1'b0, 32'h0800_0000, 16'h0000, "R10 other kept");
        do_flush(32'h0000_0020, 1'b0, 32'h1800_0020, 16'h0000, "R10 new value");

        // R7 irregular stalls on buffer 1, translated
        do_flush(32'hFFFF_FFE0, 1'b1, 32'h1FFF_FFE0, 16'hB6D3, "R7 stall");

        // R8 R9 writes and commands during a burst on buffer 0
        @(negedge clk);
        flush_valid = 1'b1; flush_addr = 32'h0000_0000; flush_xlat = 1'b0;
        @(negedge clk);
        flush_valid = 1'b0;
        #5;
        chk("R8 busy not ready", {31'b0, flush_ready}, 32'd0);
        chk("R7 held beat0", bw_data, exp_mem[0]);
        cpu_idx = 4'd9;
        #1 chk("R9 other buffer ready", {31'b0, cpu_wr_ready}, 32'd1);
        cpu_idx = 4'd2;
        #1 chk("R9 busy buffer blocked", {31'b0, cpu_wr_ready}, 32'd0);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_idx = 4'd2; cpu_wdata = 32'hDEAD_0002;
        flush_valid = 1'b1; flush_addr = 32'h0000_0020;
        #5 chk("R7 held after stall", bw_data, exp_mem[0]);
        @(negedge clk);
        cpu_idx = 4'd9; cpu_wdata = 32'hBEEF_0009; flush_valid = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
        exp_mem[9] = 32'hBEEF_0009;
        run_beats(0, 32'h0800_0000, 16'h0000, "R9 busy burst");
        repeat (3) begin
            @(negedge clk);
            #5 chk("R8 dropped flush", {31'b0, bw_valid}, 32'd0);
        end
        cpu_idx = 4'd2;
        #1 chk("R9 blocked write ignored", cpu_rdata, exp_mem[2]);
        cpu_idx = 4'd9;
        #1 chk("R9 other write taken", cpu_rdata, 32'hBEEF_0009);

        summary();
    end

endmodule